// File: doc/BRIEF.md
# Bottle Vending Sequencer

This block is the supervising state machine of a bottle vending machine. A coin sensor raises a flag while a coin is passing. An external accumulator keeps the inserted sum and reports three comparison flags against the one-euro price: below, equal, above. Two mechanical units each answer with a done pulse: the bottle dispenser and the change unit. The sequencer turns these flags into four commands. It can release a bottle, clear the sum, lower the sum by ten cents, or pay out one ten-cent coin.

The machine is a Moore machine with seven states. A coin is registered once its flag drops again. The machine then compares the sum with the price. If the sum is short, it waits for more coins. If the sum matches, it releases a bottle and then clears the sum. If the sum is too high, it runs a change loop that pays out ten cents and lowers the sum by the same amount. The loop repeats until the comparison reports a match. Each command depends only on the present state.

The states use a fixed three-bit code chosen so that the decoders stay small:

| State | Code |
|-------|------|
| idle | 000 |
| latch | 001 |
| judge | 011 |
| dispense | 110 |
| clear | 111 |
| payout | 100 |
| step-down | 101 |

The one unused code, 010, leads back to idle on the next clock.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine enters idle. All four command outputs are 0 after that edge.
- R2: In idle the machine moves to latch when `coin_seen` is 1 and stays in idle otherwise. Idle, latch and judge drive all commands to 0.
- R3: Latch holds as long as `coin_seen` stays 1. It moves to judge on the first edge with `coin_seen` at 0.
- R4: Judge moves to idle when `sum_lt` is 1. Otherwise it moves to dispense when `sum_eq` is 1. Otherwise it moves to payout when `sum_gt` is 1. With no flag set, it stays in judge. The priority is lt, then eq, then gt.
- R5: Dispense drives `dispense_req` to 1 and holds until `dispense_done` is 1. It then moves to clear.
- R6: Clear drives `sum_clear` to 1 for exactly one cycle. It then returns to idle regardless of the inputs.
- R7: Payout drives `payout_dime` to 1 and holds until `change_done` is 1. It then moves to step-down.
- R8: Step-down drives `sum_step_down` to 1 for exactly one cycle. It then returns to judge regardless of the inputs.
- R9: At most one of the four command outputs is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| coin_seen | input | 1 | Coin sensor flag |
| sum_lt | input | 1 | Sum is below one euro |
| sum_eq | input | 1 | Sum equals one euro |
| sum_gt | input | 1 | Sum is above one euro |
| dispense_done | input | 1 | Dispenser has finished |
| change_done | input | 1 | Change unit has paid a coin |
| dispense_req | output | 1 | Release one bottle |
| sum_clear | output | 1 | Clear the accumulator |
| sum_step_down | output | 1 | Lower the accumulator by ten cents |
| payout_dime | output | 1 | Pay out one ten-cent coin |

## Verification
The main sequence is driven with three kinds of coin sequence. An exact payment separates the dispense path from the change path. An overpayment drives two rounds of the change loop before it settles on a match, which shows that step-down returns to judge and not to idle. A short sum shows that the machine goes back to idle and accepts another coin.

Done signals are held off for several cycles to tell a holding state apart from a one-cycle pass. A coin flag held high shows that latch waits for the coin to leave. Setting several comparison flags at once exposes the priority order. A reset taken in the middle of a payout proves that the machine recovers.

// File: rtl/vend_pkg.sv
package vend_pkg;

    localparam int STATE_W = 3;
    localparam int CMD_W   = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 3'b000,
        ST_LATCH    = 3'b001,
        ST_JUDGE    = 3'b011,
        ST_DISPENSE = 3'b110,
        ST_CLEAR    = 3'b111,
        ST_PAYOUT   = 3'b100,
        ST_STEPDOWN = 3'b101
    } vend_state_t;

    typedef struct packed {
        logic coin;
        logic lt;
        logic eq;
        logic gt;
        logic disp_done;
        logic chg_done;
    } vend_in_t;

    typedef struct packed {
        logic dispense;
        logic clear;
        logic step_down;
        logic payout;
    } vend_cmd_t;

    localparam vend_cmd_t CMD_NONE = '0;

    // Three-way decision taken in the judge state, lt has highest priority
    function automatic vend_state_t judge_next(input vend_in_t i);
        if (i.lt)      return ST_IDLE;
        else if (i.eq) return ST_DISPENSE;
        else if (i.gt) return ST_PAYOUT;
        else           return ST_JUDGE;
    endfunction

endpackage

// File: rtl/vend_state_reg.sv
module vend_state_reg
    import vend_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  vend_state_t nxt,
    output vend_state_t cur
);

    always_ff @(posedge clk) begin
        if (rst) cur <= ST_IDLE;
        else     cur <= nxt;
    end

endmodule

// File: rtl/vend_next_state.sv
module vend_next_state
    import vend_pkg::*;
(
    input  vend_state_t cur,
    input  vend_in_t    ins,
    output vend_state_t nxt
);

    always_comb begin
        case (cur)
            ST_IDLE:     nxt = ins.coin ? ST_LATCH : ST_IDLE;
            ST_LATCH:    nxt = ins.coin ? ST_LATCH : ST_JUDGE;
            ST_JUDGE:    nxt = judge_next(ins);
            ST_DISPENSE: nxt = ins.disp_done ? ST_CLEAR : ST_DISPENSE;
            ST_CLEAR:    nxt = ST_IDLE;
            ST_PAYOUT:   nxt = ins.chg_done ? ST_STEPDOWN : ST_PAYOUT;
            ST_STEPDOWN: nxt = ST_JUDGE;
            default:     nxt = ST_IDLE;   // unused code 010 recovers
        endcase
    end

endmodule

// File: rtl/vend_out_decode.sv
module vend_out_decode
    import vend_pkg::*;
(
    input  vend_state_t cur,
    output vend_cmd_t   cmd
);

    always_comb begin
        cmd = CMD_NONE;
        case (cur)
            ST_DISPENSE: cmd.dispense  = 1'b1;
            ST_CLEAR:    cmd.clear     = 1'b1;
            ST_PAYOUT:   cmd.payout    = 1'b1;
            ST_STEPDOWN: cmd.step_down = 1'b1;
            default:     cmd = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic coin_seen,
    input  logic sum_lt,
    input  logic sum_eq,
    input  logic sum_gt,
    input  logic dispense_done,
    input  logic change_done,
    output logic dispense_req,
    output logic sum_clear,
    output logic sum_step_down,
    output logic payout_dime
);

    vend_in_t    ins;
    vend_state_t cur_st;
    vend_state_t nxt_st;
    vend_cmd_t   cmd;

    assign ins = '{coin: coin_seen, lt: sum_lt, eq: sum_eq, gt: sum_gt,
                   disp_done: dispense_done, chg_done: change_done};

    vend_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_st),
        .cur (cur_st)
    );

    vend_next_state u_nxt (
        .cur (cur_st),
        .ins (ins),
        .nxt (nxt_st)
    );

    vend_out_decode u_out (
        .cur (cur_st),
        .cmd (cmd)
    );

    assign dispense_req  = cmd.dispense;
    assign sum_clear     = cmd.clear;
    assign sum_step_down = cmd.step_down;
    assign payout_dime   = cmd.payout;

endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic coin_seen,
    input logic sum_lt,
    input logic sum_eq,
    input logic sum_gt,
    input logic dispense_done,
    input logic change_done,
    input logic dispense_req,
    input logic sum_clear,
    input logic sum_step_down,
    input logic payout_dime
);

    logic [3:0] cmds;
    assign cmds = {dispense_req, sum_clear, sum_step_down, payout_dime};

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (cmds == 4'b0000));

    assert_dispense_from_eq_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(dispense_req) |-> $past(sum_eq && !sum_lt));

    assert_payout_entry_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(payout_dime) && !$past(rst)) |-> $past(sum_gt && !sum_lt && !sum_eq));

    assert_dispense_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (dispense_req && !dispense_done) |=> dispense_req);

    assert_dispense_exit_R5: assert property (@(posedge clk) disable iff (rst)
        (dispense_req && dispense_done) |=> sum_clear);

    assert_clear_single_R6: assert property (@(posedge clk) disable iff (rst)
        sum_clear |=> (cmds == 4'b0000));

    assert_payout_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (payout_dime && !change_done) |=> payout_dime);

    assert_payout_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (payout_dime && change_done) |=> sum_step_down);

    assert_step_single_R8: assert property (@(posedge clk) disable iff (rst)
        sum_step_down |=> (cmds == 4'b0000));

    assert_one_cmd_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmds));

endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .coin_seen     (coin_seen),
    .sum_lt        (sum_lt),
    .sum_eq        (sum_eq),
    .sum_gt        (sum_gt),
    .dispense_done (dispense_done),
    .change_done   (change_done),
    .dispense_req  (dispense_req),
    .sum_clear     (sum_clear),
    .sum_step_down (sum_step_down),
    .payout_dime   (payout_dime)
);

// File: tb/vend_ctrl_tb_top.sv
module vend_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic coin_seen = 1'b0;
    logic sum_lt = 1'b0;
    logic sum_eq = 1'b0;
    logic sum_gt = 1'b0;
    logic dispense_done = 1'b0;
    logic change_done = 1'b0;
    logic dispense_req, sum_clear, sum_step_down, payout_dime;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [3:0] cmds;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // Input vector: {coin, lt, eq, gt, disp_done, chg_done}
    localparam logic [5:0] IN_NONE = 6'b000000;
    localparam logic [5:0] IN_COIN = 6'b100000;
    localparam logic [5:0] IN_LT   = 6'b010000;
    localparam logic [5:0] IN_EQ   = 6'b001000;
    localparam logic [5:0] IN_GT   = 6'b000100;
    localparam logic [5:0] IN_DD   = 6'b000010;
    localparam logic [5:0] IN_CD   = 6'b000001;

    // Expected commands: {dispense, clear, step_down, payout}
    localparam logic [3:0] C_NONE = 4'b0000;
    localparam logic [3:0] C_DISP = 4'b1000;
    localparam logic [3:0] C_CLR  = 4'b0100;
    localparam logic [3:0] C_STEP = 4'b0010;
    localparam logic [3:0] C_PAY  = 4'b0001;

    always #5 clk = ~clk;

    vend_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .coin_seen     (coin_seen),
        .sum_lt        (sum_lt),
        .sum_eq        (sum_eq),
        .sum_gt        (sum_gt),
        .dispense_done (dispense_done),
        .change_done   (change_done),
        .dispense_req  (dispense_req),
        .sum_clear     (sum_clear),
        .sum_step_down (sum_step_down),
        .payout_dime   (payout_dime)
    );

    // Driver: apply inputs for one edge and queue what must follow it
    task automatic step(input logic r, input logic [5:0] iv,
                        input logic [3:0] exp_cmds, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r;
        {coin_seen, sum_lt, sum_eq, sum_gt, dispense_done, change_done} = iv;
        e.cmds = exp_cmds;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare after each edge, clear of the edge itself
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            logic [3:0] act;
            e = sb_q.pop_front();
            act = {dispense_req, sum_clear, sum_step_down, payout_dime};
            n_tests++;
            if (act !== e.cmds) begin
                n_fail++;
                $display("FAIL %s: commands actual %b expected %b", e.tag, act, e.cmds);
            end
            n_tests++;
            if ($countones(act) > 1) begin
                n_fail++;
                $display("FAIL R9: commands actual %b expected at most one high", act);
            end
        end
    end

    initial begin
        // R1: reset state
        step(1'b1, IN_COIN, C_NONE, "R1 reset");
        step(1'b1, IN_NONE, C_NONE, "R1 reset");
        // R2: idle ignores the comparison flags without a coin
        step(1'b0, IN_EQ,   C_NONE, "R2 idle");
        step(1'b0, IN_NONE, C_NONE, "R2 idle");
        // Exact payment, with the coin flag held for a while (R3)
        step(1'b0, IN_COIN, C_NONE, "R2 to latch");
        step(1'b0, IN_COIN | IN_EQ, C_NONE, "R3 latch hold");
        step(1'b0, IN_COIN | IN_EQ, C_NONE, "R3 latch hold");
        step(1'b0, IN_NONE, C_NONE, "R3 to judge");
        step(1'b0, IN_NONE, C_NONE, "R4 judge waits");
        step(1'b0, IN_EQ,   C_DISP, "R4 eq to dispense");
        step(1'b0, IN_CD,   C_DISP, "R5 dispense hold");
        step(1'b0, IN_NONE, C_DISP, "R5 dispense hold");
        step(1'b0, IN_DD,   C_CLR,  "R5 to clear");
        step(1'b0, IN_COIN | IN_DD, C_NONE, "R6 clear to idle");
        step(1'b0, IN_NONE, C_NONE, "R6 idle after clear");
        // Short sum returns to idle, then a new coin is accepted
        step(1'b0, IN_COIN, C_NONE, "R2 to latch");
        step(1'b0, IN_NONE, C_NONE, "R3 to judge");
        step(1'b0, IN_LT,   C_NONE, "R4 lt to idle");
        step(1'b0, IN_EQ,   C_NONE, "R4 idle after lt");
        step(1'b0, IN_COIN, C_NONE, "R2 to latch");
        step(1'b0, IN_NONE, C_NONE, "R3 to judge");
        // Overpayment: two rounds of change
        step(1'b0, IN_GT,   C_PAY,  "R4 gt to payout");
        step(1'b0, IN_DD,   C_PAY,  "R7 payout hold");
        step(1'b0, IN_CD,   C_STEP, "R7 to step-down");
        step(1'b0, IN_COIN | IN_EQ, C_NONE, "R8 step-down to judge");
        step(1'b0, IN_GT,   C_PAY,  "R8 judge again");
        step(1'b0, IN_CD,   C_STEP, "R7 to step-down");
        step(1'b0, IN_NONE, C_NONE, "R8 to judge");
        step(1'b0, IN_EQ,   C_DISP, "R4 eq after change");
        step(1'b0, IN_DD,   C_CLR,  "R5 to clear");
        step(1'b0, IN_NONE, C_NONE, "R6 to idle");
        // Priority: all flags set picks lt, then eq beats gt
        step(1'b0, IN_COIN, C_NONE, "R2 to latch");
        step(1'b0, IN_NONE, C_NONE, "R3 to judge");
        step(1'b0, IN_LT | IN_EQ | IN_GT, C_NONE, "R4 lt priority");
        step(1'b0, IN_COIN, C_NONE, "R2 to latch");
        step(1'b0, IN_NONE, C_NONE, "R3 to judge");
        step(1'b0, IN_EQ | IN_GT, C_DISP, "R4 eq over gt");
        step(1'b0, IN_DD,   C_CLR,  "R5 to clear");
        step(1'b0, IN_NONE, C_NONE, "R6 to idle");
        // Reset in the middle of a payout
        step(1'b0, IN_COIN, C_NONE, "R2 to latch");
        step(1'b0, IN_NONE, C_NONE, "R3 to judge");
        step(1'b0, IN_GT,   C_PAY,  "R4 gt to payout");
        step(1'b1, IN_NONE, C_NONE, "R1 reset in payout");
        step(1'b0, IN_CD,   C_NONE, "R1 idle after reset");
        step(1'b0, IN_NONE, C_NONE, "R1 idle after reset");
        @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule